// File: doc/BRIEF.md
# Synthesizer Divider Configuration Loader

This block is the programming front end of a clock synthesizer. It holds the active feedback divider value (9 bits), the output divider code (3 bits) and a 2-bit test-select code. It hands the divider values to the divider logic, drives a test pin through a 4-way selector, and flags whether the feedback value lies in the range where the loop can lock. The loop itself, the oscillator and the output buffers are outside this block.

There are two ways to load the settings. In parallel mode, which is selected by holding `parHold` low, the divider pins pass through to the active registers. Raising `parHold` latches the values. In serial mode, which is selected by holding `parHold` high, a 19-bit frame is shifted in on `serClk` and moved into the active registers by `serStrobe`. The serial clock and the strobes are ordinary synchronous inputs. The block samples them on `clk` and detects their edges, so every register lives in one clock domain.

Top module: `synth_cfg_loader`

## Requirements
- R1: During reset and right after it, `mActive`, `naActive`, `testSel` and `auxBits` are zero, the shift register is zero, and `testOut` is low.
- R2: While `parHold` is low, `mActive` and `naActive` take the values of `mPins` and `naPins` on every `clk` edge, one cycle after the pins.
- R3: Once `parHold` is high, `mActive` and `naActive` keep the last values loaded while `parHold` was low. Pin changes have no effect until a serial transfer happens or `parHold` goes low again.
- R4: With `parHold` high and `serStrobe` low, each rising edge of `serClk` shifts `serData` into the LSB of a 19-bit shift register. The active registers stay unchanged.
- R5: A rising edge of `serStrobe` with `parHold` high copies the frame into the active registers. The frame is described from the first bit shifted (bit 18) to the last (bit 0):
  - bits 18..15: four spread-spectrum bits;
  - bit 14: test-select high bit;
  - bit 13: test-select low bit;
  - bit 12: an unused bit;
  - bits 11..9: the output divider code, MSB first;
  - bits 8..0: the feedback value, MSB first.
- R6: While `serStrobe` stays high in serial mode, each rising edge of `serClk` shifts in one bit and then loads the active registers from the shifted contents.
- R7: After `serStrobe` falls, the active registers are frozen. Further shifting leaves them unchanged.
- R8: In serial mode, `testOut` follows `testSel`:
  - 00 drives low;
  - 01 drives the shift register's bit 18 (its serial output);
  - 10 drives `mDivFb`;
  - 11 drives `outClkRef`.
- R9: `testOut` is low whenever `parHold` is low, whatever `testSel` holds.
- R10: `mInRange` is high exactly when `mActive` lies between 23 and 30 inclusive.
- R11: The four spread-spectrum bits and the unused bit of a transferred frame appear on `auxBits` as {ssc[3:0], unused}. They have no effect on any other output.
- R12: `serClk` edges while `parHold` is low leave the shift register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| parHold | input | 1 | Low: parallel pass-through; high: latch and serial mode |
| serClk | input | 1 | Serial shift clock, sampled on clk |
| serData | input | 1 | Serial frame data |
| serStrobe | input | 1 | Serial transfer strobe |
| mPins | input | 9 | Parallel feedback divider value |
| naPins | input | 3 | Parallel output divider code |
| mDivFb | input | 1 | Feedback divider output, routed to the test pin |
| outClkRef | input | 1 | Output-rate signal, routed to the test pin |
| mActive | output | 9 | Active feedback divider value |
| naActive | output | 3 | Active output divider code |
| testSel | output | 2 | Active test-select code |
| auxBits | output | 5 | Captured spread-spectrum bits and unused bit |
| testOut | output | 1 | Test pin |
| mInRange | output | 1 | Feedback value is within the lock range |

## Verification
The assertions check on every cycle:
- parallel pass-through with one cycle of delay;
- that the active registers hold still whenever parallel mode is off and the strobe is low, which covers both latching and freezing;
- that the test pin is forced low in parallel mode;
- the feedback routing of the selector;
- the range flag and the reset values.

Only the bench scenarios can show the frame bit order and the transparent reload while the strobe is held high. The same holds for a shift register left untouched by serial clocks in parallel mode, which only shows up after a later strobe-only transfer.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  localparam int M_WIDTH   = 9;
  localparam int NA_WIDTH  = 3;
  localparam int SSC_WIDTH = 4;
  localparam int M_LOCK_LO = 23;
  localparam int M_LOCK_HI = 30;

  // strobes from control to datapath
  typedef struct packed {
    logic serMode;   // parallel-load input high
    logic shiftEn;   // shift one bit this cycle
    logic loadSer;   // copy shift contents (after shift) into active regs
  } cfgStrobes_t;

  typedef enum logic [1:0] {
    TSEL_LOW  = 2'b00,
    TSEL_SHFT = 2'b01,
    TSEL_MFB  = 2'b10,
    TSEL_OCLK = 2'b11
  } testSel_e;
endpackage

// File: rtl/synth_cfg_ctrl.sv
module synth_cfg_ctrl
  import synth_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        parHold,
  input  logic        serClk,
  input  logic        serStrobe,
  output cfgStrobes_t strobes
);
  logic serClkQ;
  logic strobeQ;
  logic clkRise;
  logic strobeRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      serClkQ <= 1'b0;
      strobeQ <= 1'b0;
    end else begin
      serClkQ <= serClk;
      strobeQ <= serStrobe;
    end
  end

  assign clkRise    = serClk & ~serClkQ;
  assign strobeRise = serStrobe & ~strobeQ;

  always_comb begin
    strobes.serMode = parHold;
    strobes.shiftEn = parHold & clkRise;
    // transfer on strobe rise, or transparently while held high
    strobes.loadSer = parHold & (strobeRise | (serStrobe & clkRise));
  end
endmodule

// File: rtl/synth_cfg_datapath.sv
module synth_cfg_datapath
  import synth_cfg_pkg::*;
#(
  parameter int MW   = M_WIDTH,
  parameter int NAW  = NA_WIDTH,
  parameter int SSCW = SSC_WIDTH
) (
  input  logic            clk,
  input  logic            rstN,
  input  cfgStrobes_t     strobes,
  input  logic            serData,
  input  logic [MW-1:0]   mPins,
  input  logic [NAW-1:0]  naPins,
  input  logic            mDivFb,
  input  logic            outClkRef,
  output logic [MW-1:0]   mActive,
  output logic [NAW-1:0]  naActive,
  output logic [1:0]      testSel,
  output logic [SSCW:0]   auxBits,
  output logic            testOut
);
  localparam int NA_LSB   = MW;
  localparam int UNUSED_P = MW + NAW;
  localparam int T0_P     = UNUSED_P + 1;
  localparam int T1_P     = UNUSED_P + 2;
  localparam int SSC_LSB  = UNUSED_P + 3;
  localparam int FRAME_W  = SSC_LSB + SSCW;

  logic [FRAME_W-1:0] shiftReg;
  logic [FRAME_W-1:0] shiftNext;

  always_comb begin
    shiftNext = shiftReg;
    if (strobes.shiftEn) shiftNext = {shiftReg[FRAME_W-2:0], serData};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else       shiftReg <= shiftNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mActive  <= '0;
      naActive <= '0;
      testSel  <= '0;
      auxBits  <= '0;
    end else if (!strobes.serMode) begin
      mActive  <= mPins;
      naActive <= naPins;
    end else if (strobes.loadSer) begin
      mActive  <= shiftNext[MW-1:0];
      naActive <= shiftNext[NA_LSB +: NAW];
      testSel  <= {shiftNext[T1_P], shiftNext[T0_P]};
      auxBits  <= {shiftNext[SSC_LSB +: SSCW], shiftNext[UNUSED_P]};
    end
  end

  always_comb begin
    testOut = 1'b0;
    if (strobes.serMode) begin
      case (testSel_e'(testSel))
        TSEL_LOW:  testOut = 1'b0;
        TSEL_SHFT: testOut = shiftReg[FRAME_W-1];
        TSEL_MFB:  testOut = mDivFb;
        TSEL_OCLK: testOut = outClkRef;
        default:   testOut = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader
  import synth_cfg_pkg::*;
#(
  parameter int MW    = M_WIDTH,
  parameter int NAW   = NA_WIDTH,
  parameter int SSCW  = SSC_WIDTH,
  parameter int M_LO  = M_LOCK_LO,
  parameter int M_HI  = M_LOCK_HI
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           parHold,
  input  logic           serClk,
  input  logic           serData,
  input  logic           serStrobe,
  input  logic [MW-1:0]  mPins,
  input  logic [NAW-1:0] naPins,
  input  logic           mDivFb,
  input  logic           outClkRef,
  output logic [MW-1:0]  mActive,
  output logic [NAW-1:0] naActive,
  output logic [1:0]     testSel,
  output logic [SSCW:0]  auxBits,
  output logic           testOut,
  output logic           mInRange
);
  localparam logic [MW-1:0] LO_V = MW'(M_LO);
  localparam logic [MW-1:0] HI_V = MW'(M_HI);

  cfgStrobes_t strobes;

  synth_cfg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .parHold(parHold), .serClk(serClk),
    .serStrobe(serStrobe), .strobes(strobes)
  );

  synth_cfg_datapath #(.MW(MW), .NAW(NAW), .SSCW(SSCW)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .serData(serData),
    .mPins(mPins), .naPins(naPins), .mDivFb(mDivFb), .outClkRef(outClkRef),
    .mActive(mActive), .naActive(naActive), .testSel(testSel),
    .auxBits(auxBits), .testOut(testOut)
  );

  assign mInRange = (mActive >= LO_V) && (mActive <= HI_V);
endmodule

// File: rtl/synth_cfg_checker.sv
module synth_cfg_checker #(
  parameter int MW   = 9,
  parameter int NAW  = 3,
  parameter int SSCW = 4,
  parameter int M_LO = 23,
  parameter int M_HI = 30
) (
  input logic           clk,
  input logic           rstN,
  input logic           parHold,
  input logic           serStrobe,
  input logic [MW-1:0]  mPins,
  input logic [NAW-1:0] naPins,
  input logic           mDivFb,
  input logic [MW-1:0]  mActive,
  input logic [NAW-1:0] naActive,
  input logic [1:0]     testSel,
  input logic [SSCW:0]  auxBits,
  input logic           testOut,
  input logic           mInRange
);
  logic pastValid;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    !rstN |=> (mActive == '0 && naActive == '0 && testSel == '0 && auxBits == '0 && !testOut));

  a_r2_par_follow: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(!parHold)) |-> (mActive == $past(mPins) && naActive == $past(naPins)));

  // covers latching (R3), shifting without transfer (R4) and freeze (R7)
  a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(parHold) && !$past(serStrobe)) |-> ($stable(mActive) && $stable(naActive) && $stable(testSel)));

  a_r8_mfb_route: assert property (@(posedge clk) disable iff (!rstN)
    (parHold && testSel == 2'b10) |-> (testOut == mDivFb));

  a_r8_sel_low: assert property (@(posedge clk) disable iff (!rstN)
    (testSel == 2'b00) |-> !testOut);

  a_r9_par_test_low: assert property (@(posedge clk) disable iff (!rstN)
    !parHold |-> !testOut);

  a_r10_range_in: assert property (@(posedge clk) disable iff (!rstN)
    mInRange |-> (int'(mActive) >= M_LO && int'(mActive) <= M_HI));

  a_r10_range_out: assert property (@(posedge clk) disable iff (!rstN)
    (int'(mActive) >= M_LO && int'(mActive) <= M_HI) |-> mInRange);
endmodule

bind synth_cfg_loader synth_cfg_checker #(
  .MW(MW), .NAW(NAW), .SSCW(SSCW), .M_LO(M_LO), .M_HI(M_HI)
) u_chk (
  .clk(clk), .rstN(rstN), .parHold(parHold), .serStrobe(serStrobe),
  .mPins(mPins), .naPins(naPins), .mDivFb(mDivFb), .mActive(mActive),
  .naActive(naActive), .testSel(testSel), .auxBits(auxBits),
  .testOut(testOut), .mInRange(mInRange)
);

// File: tb/tb_synth_cfg_loader.sv
`timescale 1ns/100ps
module tb_synth_cfg_loader;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic parHold = 1'b0, serClk = 1'b0, serData = 1'b0, serStrobe = 1'b0;
  logic [8:0] mPins = '0;
  logic [2:0] naPins = '0;
  logic mDivFb = 1'b0, outClkRef = 1'b0;
  logic [8:0] mActive;
  logic [2:0] naActive;
  logic [1:0] testSel;
  logic [4:0] auxBits;
  logic testOut, mInRange;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string curReq = "R1";

  always #2.5 clk = ~clk;

  synth_cfg_loader dut (
    .clk(clk), .rstN(rstN), .parHold(parHold), .serClk(serClk), .serData(serData),
    .serStrobe(serStrobe), .mPins(mPins), .naPins(naPins), .mDivFb(mDivFb),
    .outClkRef(outClkRef), .mActive(mActive), .naActive(naActive),
    .testSel(testSel), .auxBits(auxBits), .testOut(testOut), .mInRange(mInRange)
  );

  // behavioural reference model
  int  refM, refNa, refT, refAux;
  bit  q[$];
  bit  pClk, pStr;

  function automatic int field(int lo, int n);
    int v = 0;
    for (int i = lo; i < lo + n; i++) v = (v << 1) | int'(q[i]);
    return v;
  endfunction

  task automatic modelReset();
    refM = 0; refNa = 0; refT = 0; refAux = 0; pClk = 0; pStr = 0;
    q.delete();
    for (int i = 0; i < 19; i++) q.push_back(1'b0);
  endtask

  function automatic bit expTest();
    if (!parHold) return 1'b0;
    case (refT)
      1: return q[0];
      2: return mDivFb;
      3: return outClkRef;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  initial modelReset();

  always @(posedge clk) begin
    if (!rstN) modelReset();
    else begin
      bit cr, sr;
      cr = serClk && !pClk;
      sr = serStrobe && !pStr;
      if (!parHold) begin
        refM = int'(mPins); refNa = int'(naPins);
      end else begin
        if (cr) begin q.push_back(serData); void'(q.pop_front()); end
        if (sr || (serStrobe && cr)) begin
          refM = field(10, 9); refNa = field(7, 3); refT = field(4, 2);
          refAux = (field(0, 4) << 1) | int'(q[6]);
        end
      end
      pClk = serClk; pStr = serStrobe;
    end
    #1;
    if (!done) begin
      chk(int'(mActive) == refM, curReq, "model mActive", int'(mActive), refM);
      chk(int'(naActive) == refNa, curReq, "model naActive", int'(naActive), refNa);
      chk(int'(testSel) == refT, curReq, "model testSel", int'(testSel), refT);
      chk(int'(auxBits) == refAux, curReq, "model auxBits", int'(auxBits), refAux);
      chk(testOut == expTest(), curReq, "model testOut", int'(testOut), int'(expTest()));
      chk(mInRange == (refM >= 23 && refM <= 30), curReq, "model mInRange",
          int'(mInRange), int'(refM >= 23 && refM <= 30));
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic serBit(bit b);
    @(negedge clk); serData = b; serClk = 1'b1;
    @(negedge clk); serClk = 1'b0;
  endtask

  task automatic sendFrame(logic [3:0] ssc, logic [1:0] t, logic u, logic [2:0] na, logic [8:0] m);
    logic [18:0] f;
    f = {ssc, t, u, na, m};
    for (int i = 18; i >= 0; i--) serBit(f[i]);
  endtask

  task automatic pulseStrobe();
    @(negedge clk); serStrobe = 1'b1;
    @(negedge clk); serStrobe = 1'b0;
    tick(1);
  endtask

  initial begin
    tick(3);
    chk(mActive == 0 && naActive == 0 && testSel == 0 && auxBits == 0 && !testOut,
        "R1", "reset state", int'(mActive), 0);
    rstN = 1'b1;

    curReq = "R2";
    mPins = 9'd25; naPins = 3'd3; tick(1);
    chk(mActive == 25 && naActive == 3, "R2", "parallel follow", int'(mActive), 25);
    chk(mInRange == 1'b1, "R10", "in range at 25", int'(mInRange), 1);
    mPins = 9'd100; tick(1);
    chk(mActive == 100 && !mInRange, "R2", "parallel follow 100", int'(mActive), 100);

    curReq = "R3";
    mPins = 9'd27; naPins = 3'd6; tick(1);
    parHold = 1'b1; mPins = 9'd5; naPins = 3'd1; tick(4);
    chk(mActive == 27 && naActive == 6, "R3", "latched values", int'(mActive), 27);

    curReq = "R4";
    sendFrame(4'b1010, 2'b01, 1'b1, 3'd5, 9'd30);
    chk(mActive == 27 && naActive == 6, "R4", "no change while shifting", int'(mActive), 27);

    curReq = "R5";
    pulseStrobe();
    chk(mActive == 30 && naActive == 5, "R5", "frame transfer M/NA", int'(mActive), 30);
    chk(testSel == 2'b01, "R5", "frame test bits", int'(testSel), 1);
    chk(auxBits == 5'b10101, "R11", "aux bits", int'(auxBits), 21);
    chk(testOut == 1'b1, "R8", "sel01 shift msb", int'(testOut), 1);

    curReq = "R7";
    serBit(1'b0); serBit(1'b1); serBit(1'b1);
    chk(mActive == 30 && naActive == 5, "R7", "frozen after strobe fall", int'(mActive), 30);

    curReq = "R6";
    sendFrame(4'b0000, 2'b00, 1'b0, 3'b110, 9'h0F0);
    @(negedge clk); serStrobe = 1'b1; tick(1);
    chk(mActive == 9'h0F0 && naActive == 3'b110, "R6", "rise load", int'(mActive), 240);
    serBit(1'b1);
    chk(mActive == 9'h1E1 && naActive == 3'b100, "R6", "transparent reload", int'(mActive), 481);
    @(negedge clk); serStrobe = 1'b0;
    curReq = "R7";
    serBit(1'b0);
    chk(mActive == 9'h1E1, "R7", "frozen after transparent", int'(mActive), 481);

    curReq = "R8";
    sendFrame(4'b0110, 2'b10, 1'b0, 3'd2, 9'd23); pulseStrobe();
    chk(mInRange == 1'b1, "R10", "lower bound 23", int'(mInRange), 1);
    chk(auxBits == 5'b01100, "R11", "aux second frame", int'(auxBits), 12);
    mDivFb = 1'b1; #1;
    chk(testOut == 1'b1, "R8", "sel10 high", int'(testOut), 1);
    mDivFb = 1'b0; #1;
    chk(testOut == 1'b0, "R8", "sel10 low", int'(testOut), 0);
    sendFrame(4'b0000, 2'b11, 1'b0, 3'd1, 9'd31); pulseStrobe();
    chk(mInRange == 1'b0, "R10", "above bound 31", int'(mInRange), 0);
    outClkRef = 1'b1; #1;
    chk(testOut == 1'b1, "R8", "sel11 high", int'(testOut), 1);
    outClkRef = 1'b0; #1;
    chk(testOut == 1'b0, "R8", "sel11 low", int'(testOut), 0);
    sendFrame(4'b1111, 2'b00, 1'b1, 3'd7, 9'd22); pulseStrobe();
    mDivFb = 1'b1; outClkRef = 1'b1; #1;
    chk(testOut == 1'b0 && !mInRange, "R8", "sel00 low, 22 out of range", int'(testOut), 0);
    sendFrame(4'b0000, 2'b00, 1'b0, 3'd0, 9'd30); pulseStrobe();
    chk(mInRange == 1'b1, "R10", "upper bound 30", int'(mInRange), 1);

    curReq = "R9";
    sendFrame(4'b0000, 2'b10, 1'b0, 3'd4, 9'd24); pulseStrobe();
    mPins = 9'd100; naPins = 3'd2;
    @(negedge clk); parHold = 1'b0; #1;
    chk(testOut == 1'b0, "R9", "parallel forces low", int'(testOut), 0);
    chk(testSel == 2'b10, "R9", "test bits kept", int'(testSel), 2);
    curReq = "R12";
    for (int i = 0; i < 5; i++) serBit(1'b1);
    chk(mActive == 100, "R2", "parallel again", int'(mActive), 100);
    @(negedge clk); parHold = 1'b1; tick(1);
    pulseStrobe();
    chk(mActive == 24 && naActive == 4, "R12", "shift reg untouched in parallel", int'(mActive), 24);

    tick(2);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule